// File: doc/BRIEF.md
# Overcurrent Fault Latch Controller

This block supervises the gate-drive path of a three-phase inverter. It takes three asynchronous logic-level inputs: a digitized overcurrent trip, an active-high drive enable, and a low-side supply undervoltage flag. It produces two registered outputs. The first is a single global shutdown line that, when high, forces all six gate outputs (three high-side, three low-side) off together. The second is an active-low fault flag.

Each input is first brought into the clock domain through a two-flop synchronizer. A trip is accepted only after it has been seen high on a number of consecutive synchronized samples, so that short switching spikes are blanked. An accepted trip latches the fault. Once the trip has gone away, the fault holds for a programmable clear time and then releases on its own. The enable input is filtered in both directions, so that short glitches of either polarity are ignored. It gates the shutdown line only and never touches the fault flag. An undervoltage raises the fault flag for as long as it lasts and is not latched.

Top module: `drive_fault_guard`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `gate_off` is 1 and `fault_n` is 1.
- R2: If `trip_in` is high on BLANK_CYC consecutive rising edges, it is accepted. `gate_off` becomes 1 and `fault_n` becomes 0 after the (BLANK_CYC+3)-th edge counted from the first edge that sees it. A trip seen on BLANK_CYC-1 edges or fewer changes neither output.
- R3: After an accepted trip falls, `fault_n` stays 0 and `gate_off` stays 1 through the (CLEAR_CYC+3)-th edge after the fall. Both release after the (CLEAR_CYC+4)-th edge, provided enable is high and there is no undervoltage.
- R4: While the accepted trip stays high, the clear timer does not run, so the fault holds however long the trip lasts.
- R5: If a new trip is accepted while the clear timer is running, the timer restarts. The release is then timed from the fall of the new trip.
- R6: If a new trip is accepted on the same edge at which the clear time would expire, the fault wins and `fault_n` does not go high even for one cycle.
- R7: Once a low level on `en_in` has persisted for EN_FILT_CYC synchronized samples, `gate_off` becomes 1 after the (EN_FILT_CYC+3)-th edge. A rising level is treated the same way. Pulses of either level shorter than EN_FILT_CYC samples are ignored. The enable never changes `fault_n` and is not latched.
- R8: A high `uv_in` drives `fault_n` to 0 after the third edge. `fault_n` returns to 1 after the third edge once `uv_in` falls. Undervoltage alone is not latched and does not change `gate_off`.
- R9: Encodings: `gate_off` = 1 means all six gate outputs are forced off. `fault_n` = 0 means a fault is present. Both are driven straight from flip-flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_in | input | 1 | Asynchronous digitized overcurrent trip, active high |
| en_in | input | 1 | Asynchronous drive enable, active high |
| uv_in | input | 1 | Asynchronous low-side supply undervoltage flag, active high |
| gate_off | output | 1 | Global shutdown; 1 forces all six gate outputs off |
| fault_n | output | 1 | Fault flag, active low |

## Verification
The sharpest coincidence is a newly accepted trip landing on the very edge at which the clear timer would expire. A directed case releases a trip and then re-raises it exactly CLEAR_CYC+1-BLANK_CYC cycles later, so that its blanking ends on the expiry edge. It is judged by requiring `fault_n` to stay low on every cycle in between. The second overlap is a trip acceptance or release while the enable filter is changing state. Segments of random toggling at several rates push both together, and each cycle's outputs are compared against a bench model built from the requirement timings.

// File: rtl/drive_fault_guard_pkg.sv
package drive_fault_guard_pkg;

  // Synchronized view of the three asynchronous inputs.
  typedef struct packed {
    logic uv;
    logic en;
    logic trip;
  } guard_in_t;

  // Counter width able to hold values 0..n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dg_sync.sv
module dg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/dg_qualify.sv
module dg_qualify
  import drive_fault_guard_pkg::*;
#(
  parameter int HOLD = 4,
  parameter bit SYMM = 1'b1   // 1: both levels filtered; 0: only the rise is qualified
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  localparam int CW = cnt_width(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;
  logic          q;

  generate
    if (SYMM) begin : g_both
      always_ff @(posedge clk) begin
        if (rst) begin
          q   <= 1'b0;
          cnt <= '0;
        end else if (d_i == q) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          q   <= d_i;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) begin
          q   <= 1'b0;
          cnt <= '0;
        end else if (!d_i) begin
          q   <= 1'b0;
          cnt <= '0;
        end else if (!q) begin
          if (cnt == LAST) begin
            q   <= 1'b1;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  endgenerate

  assign q_o = q;

  AST_RISE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> ($past(cnt) == LAST)); // R2

  AST_STEADY_WHEN_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (d_i == q) |=> $stable(q)); // R7

endmodule

// File: rtl/dg_fault_hold.sv
module dg_fault_hold
  import drive_fault_guard_pkg::*;
#(
  parameter int CLEAR = 165000
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_i,
  output logic held_o
);

  localparam int TW = cnt_width(CLEAR);
  localparam logic [TW-1:0] EXPIRE = TW'(CLEAR - 1);

  logic          held;
  logic [TW-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= 1'b0;
      timer <= '0;
    end else if (trip_i) begin
      held  <= 1'b1;
      timer <= '0;
    end else if (held) begin
      if (timer == EXPIRE) begin
        held  <= 1'b0;
        timer <= '0;
      end else begin
        timer <= timer + 1'b1;
      end
    end
  end

  assign held_o = held;

  AST_RELEASE_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    $fell(held) |-> ($past(timer) == EXPIRE)); // R3

  AST_TIMER_PARKED: assert property (@(posedge clk) disable iff (rst)
    trip_i |=> (timer == '0)); // R4

  AST_RETRIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    trip_i |=> held); // R5

endmodule

// File: rtl/drive_fault_guard.sv
module drive_fault_guard
  import drive_fault_guard_pkg::*;
#(
  parameter int BLANK_CYC   = 15,
  parameter int CLEAR_CYC   = 165000,
  parameter int EN_FILT_CYC = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_in,
  input  logic en_in,
  input  logic uv_in,
  output logic gate_off,
  output logic fault_n
);

  guard_in_t raw, syn;
  logic      trip_q, en_q, held;
  logic      gate_off_r, fault_n_r;

  assign raw = '{uv: uv_in, en: en_in, trip: trip_in};

  dg_sync #(.W($bits(guard_in_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d_i (raw), .q_o (syn)
  );

  dg_qualify #(.HOLD(BLANK_CYC), .SYMM(1'b0)) u_blank (
    .clk (clk), .rst (rst), .d_i (syn.trip), .q_o (trip_q)
  );

  dg_qualify #(.HOLD(EN_FILT_CYC), .SYMM(1'b1)) u_enfilt (
    .clk (clk), .rst (rst), .d_i (syn.en), .q_o (en_q)
  );

  dg_fault_hold #(.CLEAR(CLEAR_CYC)) u_hold (
    .clk (clk), .rst (rst), .trip_i (trip_q), .held_o (held)
  );

  // Registered outputs; reset state is the safe one: drive off, no fault.
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_off_r <= 1'b1;
      fault_n_r  <= 1'b1;
    end else begin
      gate_off_r <= trip_q | held | ~en_q;
      fault_n_r  <= ~(trip_q | held | syn.uv);
    end
  end

  assign gate_off = gate_off_r;
  assign fault_n  = fault_n_r;

  AST_TRIP_SHUTS_ALL: assert property (@(posedge clk) disable iff (rst)
    trip_q |=> (gate_off && !fault_n)); // R2

  AST_UV_FLAGS: assert property (@(posedge clk) disable iff (rst)
    syn.uv |=> !fault_n); // R8

  AST_DISABLE_GATES: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> gate_off); // R7

endmodule

// File: tb/drive_fault_guard_bench.sv
module drive_fault_guard_bench;

  localparam int BLANK = 4;
  localparam int CLEAR = 30;
  localparam int EFILT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip_in = 1'b0, en_in = 1'b1, uv_in = 1'b0;
  logic gate_off, fault_n;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  drive_fault_guard #(
    .BLANK_CYC(BLANK), .CLEAR_CYC(CLEAR), .EN_FILT_CYC(EFILT), .SYNC_STAGES(2)
  ) u_drive_fault_guard (
    .clk(clk), .rst(rst), .trip_in(trip_in), .en_in(en_in), .uv_in(uv_in),
    .gate_off(gate_off), .fault_n(fault_n)
  );

  // Reference model, built from the requirement timings.
  logic t1, t2, e1, e2, u1, u2;
  int   trun, egap, gone;
  logic m_trip, m_en, m_latch, m_goff, m_fn;

  function automatic logic exp_gate(input logic tq, input logic lt, input logic eq);
    return tq || lt || !eq;
  endfunction

  function automatic logic exp_fault_n(input logic tq, input logic lt, input logic uv);
    return !(tq || lt || uv);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {t1, t2, e1, e2, u1, u2} <= '0;
      trun <= 0; egap <= 0; gone <= 0;
      m_trip <= 1'b0; m_en <= 1'b0; m_latch <= 1'b0;
      m_goff <= 1'b1; m_fn <= 1'b1;
    end else begin
      t1 <= trip_in; t2 <= t1;
      e1 <= en_in;   e2 <= e1;
      u1 <= uv_in;   u2 <= u1;
      // trip accepted on the BLANK-th consecutive high sample, dropped at once
      if (!t2) begin
        trun <= 0; m_trip <= 1'b0;
      end else begin
        trun <= (trun < BLANK) ? trun + 1 : trun;
        if (trun + 1 >= BLANK) m_trip <= 1'b1;
      end
      // enable follows a level held for EFILT consecutive samples
      if (e2 == m_en) egap <= 0;
      else if (egap + 1 == EFILT) begin m_en <= e2; egap <= 0; end
      else egap <= egap + 1;
      // fault holds CLEAR cycles after the accepted trip is gone
      if (m_trip) begin
        m_latch <= 1'b1; gone <= 0;
      end else if (m_latch) begin
        if (gone + 1 == CLEAR) begin m_latch <= 1'b0; gone <= 0; end
        else gone <= gone + 1;
      end
      m_goff <= exp_gate(m_trip, m_latch, m_en);
      m_fn   <= exp_fault_n(m_trip, m_latch, u2);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Model comparison on every falling edge once out of reset.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(gate_off == m_goff, "R7 model gate_off", gate_off, m_goff);
      chk(fault_n == m_fn,    "R3 model fault_n",  fault_n,  m_fn);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic accept_and_hold(input int extra);
    trip_in = 1'b1;
    step(BLANK + 3 + extra);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    bit flag;
    void'($urandom(32'd4711));
    @(negedge clk);
    chk(gate_off == 1'b1 && fault_n == 1'b1, "R1 reset state", {gate_off, fault_n}, 2'b11);
    step(4);
    chk(gate_off == 1'b1 && fault_n == 1'b1, "R1 reset held", {gate_off, fault_n}, 2'b11);
    rst = 1'b0;
    step(1);
    chk(gate_off == 1'b1 && fault_n == 1'b1, "R1 first cycle", {gate_off, fault_n}, 2'b11);
    step(EFILT + 1);      // after EFILT+2 edges: still off
    chk(gate_off == 1'b1, "R7 enable not yet passed", gate_off, 1);
    step(1);
    chk(gate_off == 1'b0, "R7 enable rise filtered", gate_off, 0);

    // R2: short trip ignored
    trip_in = 1'b1; step(BLANK - 1); trip_in = 1'b0;
    flag = 1'b0;
    for (int i = 0; i < BLANK + 6; i++) begin
      step(1);
      if (gate_off || !fault_n) flag = 1'b1;
    end
    chk(!flag, "R2 short trip ignored", flag, 0);

    // R2: accepted trip, exact latency
    trip_in = 1'b1; step(BLANK + 2);
    chk(gate_off == 1'b0 && fault_n == 1'b1, "R2 before blanking end", {gate_off, fault_n}, 2'b01);
    step(1);
    chk(gate_off == 1'b1 && fault_n == 1'b0, "R2 trip accepted", {gate_off, fault_n}, 2'b10);

    // R4: long trip keeps fault well beyond the clear time
    step(CLEAR + 20);
    chk(fault_n == 1'b0 && gate_off == 1'b1, "R4 timer held during trip", {gate_off, fault_n}, 2'b10);

    // R3: release timed from the trip fall
    trip_in = 1'b0; step(CLEAR + 3);
    chk(fault_n == 1'b0 && gate_off == 1'b1, "R3 still latched", {gate_off, fault_n}, 2'b10);
    step(1);
    chk(fault_n == 1'b1 && gate_off == 1'b0, "R3 auto release", {gate_off, fault_n}, 2'b01);

    // R5: re-trip during clear restarts the timer
    accept_and_hold(2); trip_in = 1'b0;
    step(CLEAR / 2);
    accept_and_hold(2); trip_in = 1'b0;
    step(CLEAR + 3);
    chk(fault_n == 1'b0, "R5 restarted timer holds", fault_n, 0);
    step(1);
    chk(fault_n == 1'b1, "R5 release after restart", fault_n, 1);

    // R6: new acceptance on the expiry edge
    accept_and_hold(2); trip_in = 1'b0;
    flag = 1'b0;
    for (int i = 0; i < CLEAR + 1 - BLANK; i++) begin
      step(1);
      if (fault_n) flag = 1'b1;
    end
    trip_in = 1'b1;
    for (int i = 0; i < BLANK + 8; i++) begin
      step(1);
      if (fault_n) flag = 1'b1;
    end
    chk(!flag, "R6 no release gap on coincidence", flag, 0);
    trip_in = 1'b0; step(CLEAR + 4);
    chk(fault_n == 1'b1, "R6 later release", fault_n, 1);

    // R7: short enable drop ignored, long drop gates, fault untouched
    en_in = 1'b0; step(EFILT - 1); en_in = 1'b1;
    flag = 1'b0;
    for (int i = 0; i < EFILT + 6; i++) begin
      step(1);
      if (gate_off) flag = 1'b1;
    end
    chk(!flag, "R7 short enable drop ignored", flag, 0);
    en_in = 1'b0; step(EFILT + 2);
    chk(gate_off == 1'b0, "R7 drop not yet passed", gate_off, 0);
    step(1);
    chk(gate_off == 1'b1 && fault_n == 1'b1, "R7 enable low gates, no fault", {gate_off, fault_n}, 2'b11);
    en_in = 1'b1; step(EFILT + 3);
    chk(gate_off == 1'b0, "R7 enable restored", gate_off, 0);

    // R8: undervoltage flags fault, unlatched, no gate effect
    uv_in = 1'b1; step(2);
    chk(fault_n == 1'b1, "R8 uv before sync", fault_n, 1);
    step(1);
    chk(fault_n == 1'b0 && gate_off == 1'b0, "R8 uv fault, gate on", {gate_off, fault_n}, 2'b00);
    uv_in = 1'b0; step(3);
    chk(fault_n == 1'b1, "R8 uv not latched", fault_n, 1);
    chk(gate_off == 1'b0, "R9 gate encoding idle", gate_off, 0);

    // Random segments at several toggle rates, judged by the model.
    for (int seg = 0; seg < 12; seg++) begin
      int pt, pe, pu;
      pt = (seg % 3 == 0) ? 2 : (seg % 3 == 1) ? 12 : 35;
      pe = (seg % 4 == 0) ? 1 : 8;
      pu = (seg % 5 == 0) ? 6 : 1;
      for (int c = 0; c < 400; c++) begin
        if ($urandom % 100 < pt) trip_in = ~trip_in;
        if ($urandom % 100 < pe) en_in = ~en_in;
        if ($urandom % 100 < pu) uv_in = ~uv_in;
        step(1);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule